// File: doc/BRIEF.md
# Set/Clear Aliased Flag Register

This block keeps eight independent single-bit flags that software can change without first reading them back. Instead of writing the flag word directly, software writes a mask to one of two alias addresses. Ones in a mask written to the set alias turn the matching flags on, and ones in a mask written to the clear alias turn them off. Every other flag keeps its value, so any one flag can be changed with a single bus write. Two drivers that touch different flags cannot undo each other's change.

The flag word can be read at the base address and is also driven straight out to hardware. The bus is a plain synchronous one with a registered read path. Writes come in on a parameterised number of write ports, two by default, so that a set and a clear can land in the same cycle. When they touch the same flag, the set takes priority.

Top module: `flagreg_sc`

## Requirements
- R1: A synchronous active-high reset drives every flag to 0 and read data to 0x00.
- R2: A write to offset 1 (set alias) sets each flag whose write-data bit is 1, with data bit i acting on flag i (0x04 sets bit 2), and leaves the other flags unchanged.
- R3: A write to offset 2 (clear alias) clears each flag whose write-data bit is 1, with data bit i acting on flag i, and leaves the other flags unchanged.
- R4: A write to offset 0 (the flag word) or to the unused offset 3 changes no flag.
- R5: A read of offset 0 returns, on the cycle after the request, the flag value held when the request was sampled.
- R6: A read of offset 1, 2 or 3, or a cycle with no read request, yields read data 0x00 on the following cycle.
- R7: Writing 0x00 to either alias leaves all flags unchanged.
- R8: Set and clear masks from all write ports in one cycle are combined. A flag that is both set and cleared in the same cycle ends up 1.
- R9: The hardware flag output always equals the value that a read of offset 0 would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | NP | Write strobe, one bit per write port |
| wr_addr | input | NP*AW | Write offsets, port p in bits [p*AW +: AW] |
| wr_data | input | NP*DW | Write masks, port p in bits [p*DW +: DW] |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read offset |
| rd_data | output | DW | Registered read data, valid the cycle after rd_en |
| flags_o | output | DW | Current flag word to hardware |

## Verification
The assertions assume that reset is held from time zero for at least one edge and that every bus input carries a known value on every clock edge after reset. The read assertion also assumes that the flag word seen one edge back is already a post-reset value. The stimulus meets these assumptions by starting in reset and by driving all strobes, offsets and masks to defined values at each falling edge, returning them to zero when idle. The random phase draws offsets across all four codes and strobe patterns across both ports, so colliding set and clear masks fall within the assertions' scope.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
  // Offsets whose meaning the update logic depends on
  localparam int unsigned OFS_WORD = 0;
  localparam int unsigned OFS_SET  = 1;
  localparam int unsigned OFS_CLR  = 2;
endpackage

// File: rtl/flagreg_wdec.sv
module flagreg_wdec #(
  parameter int unsigned NP = 2,
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic [NP-1:0]    wr_en,
  input  logic [NP*AW-1:0] wr_addr,
  input  logic [NP*DW-1:0] wr_data,
  output logic [DW-1:0]    set_mask,
  output logic [DW-1:0]    clr_mask
);
  import flagreg_pkg::*;

  logic [DW-1:0] port_set [NP];
  logic [DW-1:0] port_clr [NP];

  // One decoder per write port; the word offset and spare codes decode to nothing
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    assign a = wr_addr[p*AW +: AW];
    assign d = wr_data[p*DW +: DW];
    assign port_set[p] = (wr_en[p] && a == AW'(OFS_SET)) ? d : '0;
    assign port_clr[p] = (wr_en[p] && a == AW'(OFS_CLR)) ? d : '0;
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int p = 0; p < NP; p++) begin
      set_mask |= port_set[p];
      clr_mask |= port_clr[p];
    end
  end
endmodule

// File: rtl/flagreg_state.sv
module flagreg_state #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_mask,
  input  logic [DW-1:0] clr_mask,
  output logic [DW-1:0] flags_q
);
  // Clear applied first, set ORed after it: set has priority on a shared bit
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_mask) | set_mask;
  end

  // R2 / R8: every requested set bit is 1 on the next cycle
  p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(set_mask)) == $past(set_mask)));

  // R3: a cleared bit that is not also set is 0 on the next cycle
  p_clear_lands_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(clr_mask & ~set_mask)) == '0));

  // R7: no masks means no change
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (set_mask == '0 && clr_mask == '0) |=> $stable(flags_q));

  // R2 / R3: bits outside both masks keep their value
  p_untouched_bits_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & ~$past(set_mask | clr_mask)) ==
              ($past(flags_q) & ~$past(set_mask | clr_mask))));
endmodule

// File: rtl/flagreg_rdport.sv
module flagreg_rdport #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] flags,
  output logic [DW-1:0] rd_data
);
  import flagreg_pkg::*;

  logic hit_word;
  assign hit_word = rd_en && (rd_addr == AW'(OFS_WORD));

  // Aliases are write-only: anything other than the word reads as zero
  always_ff @(posedge clk) begin
    if (rst)           rd_data <= '0;
    else if (hit_word) rd_data <= flags;
    else               rd_data <= '0;
  end

  p_word_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == AW'(OFS_WORD)) |=> (rd_data == $past(flags)));

  p_alias_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && rd_addr == AW'(OFS_WORD)) |=> (rd_data == '0));
endmodule

// File: rtl/flagreg_sc.sv
module flagreg_sc #(
  parameter int unsigned NP = 2,
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    wr_en,
  input  logic [NP*AW-1:0] wr_addr,
  input  logic [NP*DW-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    flags_o
);
  logic [DW-1:0] set_mask;
  logic [DW-1:0] clr_mask;
  logic [DW-1:0] flags_q;

  flagreg_wdec #(.NP(NP), .AW(AW), .DW(DW)) u_wdec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  flagreg_state #(.DW(DW)) u_state (
    .clk      (clk),
    .rst      (rst),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .flags_q  (flags_q)
  );

  flagreg_rdport #(.AW(AW), .DW(DW)) u_rdport (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .flags   (flags_q),
    .rd_data (rd_data)
  );

  assign flags_o = flags_q;
endmodule

// File: tb/flagreg_sc_tb.sv
`timescale 1ns/1ps
module flagreg_sc_tb;
  localparam int NP = 2;
  localparam int AW = 2;
  localparam int DW = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    wr_en = '0;
  logic [NP*AW-1:0] wr_addr = '0;
  logic [NP*DW-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [AW-1:0]    rd_addr = '0;
  logic [DW-1:0]    rd_data;
  logic [DW-1:0]    flags_o;

  always #2 clk = ~clk;

  flagreg_sc #(.NP(NP), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .flags_o(flags_o)
  );

  typedef struct { logic [DW-1:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] model = '0;
  logic rd_pend = 1'b0;
  bit done = 1'b0;

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Monitor: a read sampled at a rising edge has its data by the next falling edge
  always @(posedge clk) rd_pend <= rd_en && !rst;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R5: actual read 0x%02h expected none queued", rd_data);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rd_data, e.val, e.tag);
      end
    end
  end

  // Driver: entered at a falling edge, leaves at the next falling edge
  task automatic step(input logic [1:0] we, input logic [1:0] a0, input logic [7:0] d0,
                      input logic [1:0] a1, input logic [7:0] d1,
                      input logic re, input logic [1:0] ra, input string tag);
    logic [DW-1:0] s, c;
    exp_t e;
    wr_en   = we;
    wr_addr = {a1, a0};
    wr_data = {d1, d0};
    rd_en   = re;
    rd_addr = ra;
    if (re) begin
      e.val = (ra == 2'd0) ? model : 8'h00;
      e.tag = (ra == 2'd0) ? {tag, " R5 word read"} : {tag, " R6 alias read"};
      sb_q.push_back(e);
    end
    s = '0; c = '0;
    if (we[0] && a0 == 2'd1) s |= d0;
    if (we[0] && a0 == 2'd2) c |= d0;
    if (we[1] && a1 == 2'd1) s |= d1;
    if (we[1] && a1 == 2'd2) c |= d1;
    model = (model & ~c) | s;
    @(posedge clk);
    @(negedge clk);
    wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
    check(flags_o, model, {tag, " R9 flags_o"});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    check(flags_o, 8'h00, "R1 reset flags");
    check(rd_data, 8'h00, "R1 reset read data");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(2'b00, 0, 0, 0, 0, 1, 2'd0, "R1 word after reset");
    step(2'b01, 2'd1, 8'h04, 0, 0, 0, 0, "R2 set 0x04");
    check(flags_o, 8'h04, "R2 0x04 sets bit 2");
    step(2'b00, 0, 0, 0, 0, 1, 2'd0, "R5 readback");
    step(2'b00, 0, 0, 0, 0, 1, 2'd1, "R6 set alias");
    step(2'b00, 0, 0, 0, 0, 1, 2'd2, "R6 clear alias");
    step(2'b00, 0, 0, 0, 0, 1, 2'd3, "R6 spare offset");
    step(2'b01, 2'd0, 8'hFF, 0, 0, 1, 2'd0, "R4 word write");
    step(2'b10, 0, 0, 2'd3, 8'hFF, 1, 2'd0, "R4 spare write");
    check(flags_o, 8'h04, "R4 word and spare writes ignored");
    step(2'b01, 2'd1, 8'h00, 0, 0, 0, 0, "R7 zero set");
    step(2'b10, 0, 0, 2'd2, 8'h00, 1, 2'd0, "R7 zero clear");
    check(flags_o, 8'h04, "R7 zero masks hold");
    step(2'b01, 2'd2, 8'h04, 0, 0, 0, 0, "R3 clear 0x04");
    check(flags_o, 8'h00, "R3 bit 2 cleared");
    step(2'b01, 2'd1, 8'hA5, 0, 0, 0, 0, "R2 set 0xA5");
    step(2'b10, 0, 0, 2'd2, 8'h81, 1, 2'd0, "R3 clear 0x81 with read");
    check(flags_o, 8'h24, "R3 partial clear");
    step(2'b11, 2'd1, 8'hF0, 2'd2, 8'h3C, 0, 0, "R8 set p0 clear p1");
    check(flags_o, 8'hF0, "R8 set wins");
    step(2'b11, 2'd2, 8'hFF, 2'd1, 8'h01, 0, 0, "R8 clear p0 set p1");
    check(flags_o, 8'h01, "R8 set wins reverse ports");
    step(2'b11, 2'd1, 8'h10, 2'd1, 8'h02, 1, 2'd0, "R8 two sets merge");
    check(flags_o, 8'h13, "R8 masks ORed");
    for (int i = 0; i < 400; i++) begin
      step(2'($urandom), 2'($urandom), 8'($urandom), 2'($urandom), 8'($urandom),
           1'b1, ((i % 3) == 0) ? 2'($urandom) : 2'd0, "R8 random");
    end
    step(2'b01, 2'd1, 8'h5A, 0, 0, 0, 0, "R2 preload");
    do_reset();
    step(2'b00, 0, 0, 0, 0, 1, 2'd0, "R1 word after second reset");
    @(negedge clk); @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5: actual %0d reads pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule